// File: doc/BRIEF.md
# Sector Single-Bit ECC Encoder and Checker

This block turns the raw 32-bit parity word of a 512-byte flash sector into a compact 24-bit code. The code is written as three bytes beside the sector. When the sector is read back, the block compares that stored code with the code it has just computed and sorts the result into one of four outcomes:

- the sector is clean;
- a single data bit is wrong, and its location is reported;
- only the stored code itself has a flipped bit;
- the damage cannot be repaired.

The code drops the reserved parity bits and is stored inverted. A fully erased page, whose stored bytes are all ones, therefore checks clean with no special handling.

The block only reports where a correction is needed. It gives the byte offset inside the sector and a one-hot mask of the bit to flip. The caller applies the XOR to its own buffer. Accumulating the parity word and storing the sector are both done outside the block.

Each evaluation is requested with a one-cycle start strobe. All results are registered and appear together, one cycle later, with a done pulse.

Top module: `nand_sector_ecc1`

## Requirements
- R1: The computed code is built from the raw parity word as follows. Code bits 11:0 are raw bits 11:0. Code bits 23:12 are raw bits 27:16. Raw bits 31:28 and 15:12 have no effect on the code.
- R2: The packed 24-bit value is bitwise inverted before it is output. A raw word of zero therefore gives code bytes FF FF FF, which match an erased page.
- R3: The computed code appears on `code_b0`, `code_b1` and `code_b2`, least significant byte first. The stored code arrives the same way: `stored_b0` holds code bits 7:0 and `stored_b2` holds bits 23:16.
- R4: The difference is the computed code XOR the stored code. A zero difference gives status 2'b00 (clean), with `err_byte` = 0 and `err_mask` = 0.
- R5: The difference is correctable when its upper 12 bits XOR its lower 12 bits equal 0xFFF. In that case:
  - the status is 2'b01 (corrected);
  - `err_byte` is difference bits 23:15;
  - `err_mask` has exactly bit (difference bits 14:12) set.
- R6: A correctable pattern whose byte offset is not below the parameter SECTOR_BYTES gives status 2'b11 (uncorrectable), with a zero mask.
- R7: A difference with exactly one bit set gives status 2'b10 (error in the stored code only), with `err_byte` = 0 and `err_mask` = 0.
- R8: Any other nonzero difference gives status 2'b11 (uncorrectable), with `err_byte` = 0 and `err_mask` = 0.
- R9: `done` is high in the cycle after a cycle with `start` high, and low otherwise. All result outputs update only on a start and hold their values in between.
- R10: While and after reset, and before the first start, `done` = 0, the status is 2'b00, and all code, byte and mask outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to evaluate the current inputs |
| raw_parity | input | 32 | Raw column/row parity word of the sector |
| stored_b0 | input | 8 | Stored code, bits 7:0 |
| stored_b1 | input | 8 | Stored code, bits 15:8 |
| stored_b2 | input | 8 | Stored code, bits 23:16 |
| done | output | 1 | Result valid pulse |
| code_b0 | output | 8 | Computed code, bits 7:0 |
| code_b1 | output | 8 | Computed code, bits 15:8 |
| code_b2 | output | 8 | Computed code, bits 23:16 |
| status | output | 2 | 00 clean, 01 corrected, 10 code-only error, 11 uncorrectable |
| err_byte | output | 9 | Byte offset of the bit to flip |
| err_mask | output | 8 | One-hot mask of the bit to flip |

## Verification
Every result is due in a single cycle:

- the code bytes, status, offset, mask and `done` all change on the first rising edge after `start` is seen high;
- `done` falls one edge later.

The bench drives `start` and the data on a falling edge. It samples all outputs on the next falling edge, so exactly one register stage lies between stimulus and check. It then samples once more a cycle later to confirm that `done` has dropped and that changing the inputs without a start leaves the results unchanged. The sector-size limit is checked on a second instance built with a 256-byte sector.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  localparam int CODE_W = 24;
  localparam int HALF_W = CODE_W / 2;
  localparam int OFF_W  = CODE_W - HALF_W - 3;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'b00,
    ST_FIXED     = 2'b01,
    ST_CODE_ONLY = 2'b10,
    ST_FATAL     = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ecc1_pack.sv
module ecc1_pack
  import ecc1_pkg::*;
(
  input  logic [31:0]       raw,
  output logic [CODE_W-1:0] code
);
  // Keep the two 12-bit parity halves, skip the reserved nibbles, then invert.
  always_comb begin
    code = ~{raw[16 +: HALF_W], raw[0 +: HALF_W]};
  end
endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] diff,
  output ecc_status_e       st,
  output logic [OFF_W-1:0]  off,
  output logic [7:0]        mask
);
  logic [HALF_W-1:0] fold;
  logic [OFF_W-1:0]  cand_off;
  logic [2:0]        cand_bit;
  logic              single;

  always_comb begin
    fold     = diff[CODE_W-1 -: HALF_W] ^ diff[HALF_W-1:0];
    cand_off = diff[CODE_W-1 -: OFF_W];
    cand_bit = diff[HALF_W +: 3];
    single   = ((diff & (diff - 1'b1)) == '0);

    st   = ST_CLEAN;
    off  = '0;
    mask = '0;
    if (diff == '0) begin
      st = ST_CLEAN;
    end else if (fold == '1) begin
      if (32'(cand_off) < SECTOR_BYTES) begin
        st   = ST_FIXED;
        off  = cand_off;
        mask = 8'b1 << cand_bit;
      end else begin
        st = ST_FATAL;
      end
    end else if (single) begin
      st = ST_CODE_ONLY;
    end else begin
      st = ST_FATAL;
    end
  end
endmodule

// File: rtl/nand_sector_ecc1.sv
module nand_sector_ecc1
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] raw_parity,
  input  logic [7:0]  stored_b0,
  input  logic [7:0]  stored_b1,
  input  logic [7:0]  stored_b2,
  output logic        done,
  output logic [7:0]  code_b0,
  output logic [7:0]  code_b1,
  output logic [7:0]  code_b2,
  output logic [1:0]  status,
  output logic [8:0]  err_byte,
  output logic [7:0]  err_mask
);
  logic [CODE_W-1:0] calc_code;
  logic [CODE_W-1:0] diff;
  ecc_status_e       cls_st;
  logic [OFF_W-1:0]  cls_off;
  logic [7:0]        cls_mask;

  ecc1_pack u_pack (
    .raw  (raw_parity),
    .code (calc_code)
  );

  assign diff = calc_code ^ {stored_b2, stored_b1, stored_b0};

  ecc1_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .diff (diff),
    .st   (cls_st),
    .off  (cls_off),
    .mask (cls_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      code_b0  <= '0;
      code_b1  <= '0;
      code_b2  <= '0;
      status   <= ST_CLEAN;
      err_byte <= '0;
      err_mask <= '0;
    end else begin
      done <= start;
      if (start) begin
        code_b0  <= calc_code[7:0];
        code_b1  <= calc_code[15:8];
        code_b2  <= calc_code[23:16];
        status   <= cls_st;
        err_byte <= 9'(cls_off);
        err_mask <= cls_mask;
      end
    end
  end

  // R9: done follows start by exactly one cycle
  assert_done_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_no_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done && $stable(status) && $stable(err_mask) && $stable(code_b0));
  // R5: a correction names one bit inside the sector
  assert_fix_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    (status == ST_FIXED) |-> ($countones(err_mask) == 1) && (32'(err_byte) < SECTOR_BYTES));
  // R7 / R8: no flip mask unless a data bit is being corrected
  assert_mask_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (status != ST_FIXED) |-> (err_mask == 8'h00) && (err_byte == 9'd0));
endmodule

// File: tb/tb_nand_sector_ecc1.sv
module tb_nand_sector_ecc1;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] raw_parity;
  logic [7:0]  stored_b0, stored_b1, stored_b2;
  logic        done, done_s;
  logic [7:0]  code_b0, code_b1, code_b2, cs0, cs1, cs2;
  logic [1:0]  status, status_s;
  logic [8:0]  err_byte, err_byte_s;
  logic [7:0]  err_mask, err_mask_s;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nand_sector_ecc1 dut (
    .clk(clk), .rst(rst), .start(start), .raw_parity(raw_parity),
    .stored_b0(stored_b0), .stored_b1(stored_b1), .stored_b2(stored_b2),
    .done(done), .code_b0(code_b0), .code_b1(code_b1), .code_b2(code_b2),
    .status(status), .err_byte(err_byte), .err_mask(err_mask));

  nand_sector_ecc1 #(.SECTOR_BYTES(256)) dut_small (
    .clk(clk), .rst(rst), .start(start), .raw_parity(raw_parity),
    .stored_b0(stored_b0), .stored_b1(stored_b1), .stored_b2(stored_b2),
    .done(done_s), .code_b0(cs0), .code_b1(cs1), .code_b2(cs2),
    .status(status_s), .err_byte(err_byte_s), .err_mask(err_mask_s));

  // raw, injected diff, expected code, status, byte, mask
  localparam int VW = 32 + 24 + 24 + 2 + 9 + 8;
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0000_0000, 24'h000000, 24'hFFFFFF, 2'd0, 9'd0,   8'h00}, // R2 erased
    {32'h1234_5678, 24'h000000, 24'hDCB987, 2'd0, 9'd0,   8'h00}, // R1 R4
    {32'hF000_F000, 24'h000000, 24'hFFFFFF, 2'd0, 9'd0,   8'h00}, // R1 reserved ignored
    {32'hA5A5_C3C3, 24'h000000, 24'hA5AC3C, 2'd0, 9'd0,   8'h00}, // R3 byte order
    {32'h1234_5678, 24'h02BFD4, 24'hDCB987, 2'd1, 9'd5,   8'h08}, // R5
    {32'h0000_0000, 24'hFFF000, 24'hFFFFFF, 2'd1, 9'd511, 8'h80}, // R5 last byte
    {32'h0000_0000, 24'h000FFF, 24'hFFFFFF, 2'd1, 9'd0,   8'h01}, // R5 first byte
    {32'h1234_5678, 24'h000400, 24'hDCB987, 2'd2, 9'd0,   8'h00}, // R7
    {32'h0000_0000, 24'h800000, 24'hFFFFFF, 2'd2, 9'd0,   8'h00}, // R7 top bit
    {32'h0000_0000, 24'h000003, 24'hFFFFFF, 2'd3, 9'd0,   8'h00}, // R8
    {32'h0000_0000, 24'hFFFFFF, 24'hFFFFFF, 2'd3, 9'd0,   8'h00}, // R8 fold zero
    {32'h0000_0000, 24'h8007FF, 24'hFFFFFF, 2'd1, 9'd256, 8'h01}  // R6 inside 512
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] raw, input logic [23:0] stored);
    raw_parity = raw;
    {stored_b2, stored_b1, stored_b0} = stored;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; raw_parity = '0;
    stored_b0 = '0; stored_b1 = '0; stored_b2 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10 done", done, 0);
    chk(status == 2'd0, "R10 status", status, 0);
    chk({code_b2, code_b1, code_b0} == 24'h0, "R10 code", {code_b2, code_b1, code_b0}, 0);
    chk(err_mask == 8'h0 && err_byte == 9'd0, "R10 loc", {err_byte, err_mask}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] raw; logic [23:0] d, c; logic [1:0] s; logic [8:0] b; logic [7:0] m;
      {raw, d, c, s, b, m} = VEC[i];
      drive(raw, c ^ d);
      chk(done == 1'b1, "R9 done pulse", done, 1);
      chk({code_b2, code_b1, code_b0} == c, "R1 R2 R3 code bytes", {code_b2, code_b1, code_b0}, c);
      chk(status == s, "R4 R5 R7 R8 status", status, s);
      chk(err_byte == b, "R5 byte offset", err_byte, b);
      chk(err_mask == m, "R5 bit mask", err_mask, m);
    end

    // R9: done drops, results hold when inputs change without start
    raw_parity = 32'h0BAD_0BAD;
    {stored_b2, stored_b1, stored_b0} = 24'h123456;
    @(negedge clk);
    chk(done == 1'b0, "R9 done low", done, 0);
    chk(status == 2'd1 && err_byte == 9'd256, "R9 hold", {status, err_byte}, {2'd1, 9'd256});

    // R6 on a 256-byte sector
    drive(32'h0, 24'hFFFFFF ^ 24'h8007FF);
    chk(status_s == 2'd3, "R6 beyond sector status", status_s, 3);
    chk(err_mask_s == 8'h00, "R6 beyond sector mask", err_mask_s, 0);
    drive(32'h0, 24'hFFFFFF ^ 24'h7FA805);
    chk(status_s == 2'd1, "R6 last byte status", status_s, 1);
    chk(err_byte_s == 9'd255 && err_mask_s == 8'h04, "R6 last byte loc",
        {err_byte_s, err_mask_s}, {9'd255, 8'h04});

    // R10: reset again clears results
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(status == 2'd0 && done == 1'b0 && err_mask == 8'h0, "R10 re-reset",
        {status, done, err_mask}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule